// File: doc/BRIEF.md
# Row-Buffered Integer Matrix Multiply Engine

This block computes C = A·B for square N×N signed integer matrices that sit in memories outside it. A pulse on `start` starts a run. The block first sweeps the whole of C and writes zeros to it. It then builds the result one row at a time in a local row buffer of N accumulators.

For each row i the buffer is cleared. The engine then walks the reduction index k in the outer position and the column index j in the inner position. Each step adds A[i][k]·B[k][j] into buffer entry j. When every k is done, the finished row is copied out to C. Because successive additions go to different buffer entries, a multi-cycle multiply-add pipeline of depth `ACC_LAT` takes one new operation every cycle and never stalls.

The A and B memories are read through address ports with combinational data return. C is written through a single write port. Element (r, c) of every matrix lives at linear address r·N + c.

The controller has seven states, visited in this order:
- `ST_IDLE` waits for `start`.
- `ST_ZERO` takes N·N cycles to clear C.
- `ST_CLEAR` takes N cycles to clear the row buffer.
- `ST_ACCUM` issues N·N iterations, one per cycle.
- `ST_DRAIN` waits ACC_LAT−1 cycles for the pipeline to empty.
- `ST_WBACK` takes N cycles to copy the row to C.
- `ST_DONE` lasts one cycle.

The transitions are:
- `ST_IDLE` goes to `ST_ZERO` on start.
- `ST_ZERO` goes to `ST_CLEAR` when the sweep ends.
- `ST_CLEAR` goes to `ST_ACCUM`.
- `ST_ACCUM` goes to `ST_DRAIN` after the last iteration.
- `ST_DRAIN` goes to `ST_WBACK`.
- `ST_WBACK` goes back to `ST_CLEAR` for the next row, or to `ST_DONE` after the last row.
- `ST_DONE` goes to `ST_IDLE`.

Top module: `rowbuf_mm`

## Requirements
- R1: While reset is applied, and in the first cycle after it, `busy`, `done` and `c_we` are all 0.
- R2: The first N·N writes of a run each write the value 0, to C addresses 0, 1, …, N·N−1 in that order.
- R3: When a run ends, every C[r][c] at address r·N+c equals the sum over k of A[r][k]·B[k][c], taken modulo 2^ACC_W as a signed value. A[r][k] is read at address r·N+k and B[k][c] at address k·N+c.
- R4: In the accumulate state, A and B are read every cycle with the column index running fastest. The A address therefore changes only when the column index wraps from N−1 to 0.
- R5: A buffer entry is never read for accumulation while an earlier update to the same entry is still in the pipeline. This holds whenever N ≥ ACC_LAT ≥ 2.
- R6: A run keeps `busy` high for exactly N·N + N·(2N + N·N + ACC_LAT − 1) + 1 cycles. That is 729 cycles with the default parameters.
- R7: `done` is high for exactly one cycle per run, in the cycle after the last write-back. Nothing is written to C in that cycle.
- R8: A `start` pulse while `busy` is high has no effect on the run: its length, its `done` count and its results are unchanged.
- R9: The row buffer is cleared before each row, so no row's result contains terms from an earlier row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts a run when the block is idle |
| busy | output | 1 | High from the cycle after start through the done cycle |
| done | output | 1 | One-cycle pulse when the run finishes |
| a_addr | output | ADDR_W | Read address into A, r·N+k |
| a_data | input | DW | Signed A element at a_addr, combinational |
| b_addr | output | ADDR_W | Read address into B, k·N+c |
| b_data | input | DW | Signed B element at b_addr, combinational |
| c_we | output | 1 | Write strobe for C |
| c_addr | output | ADDR_W | Write address into C, r·N+c |
| c_data | output | ACC_W | Signed value written to C |

## Verification
Most faults inside the block show up at the C port, at two points. A bad zero sweep or bad address sequencing shows in the first N·N writes of a run. A fault in the accumulate path shows as wrong C entries at the write-back of the first affected row, at the latest about N²+2N+ACC_LAT cycles after that row starts.

Some faults corrupt state without touching the data. A miscounted drain, or a missed row wrap, changes the busy length or the done timing. The cycle count catches these once the run ends.

A read of a buffer entry that still has an update in flight produces a sum that is short by a whole partial product. The result comparison sees this, and the in-RTL hazard check flags the same cycle the read happens.

// File: rtl/mm_pkg.sv
package mm_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ZERO,
        ST_CLEAR,
        ST_ACCUM,
        ST_DRAIN,
        ST_WBACK,
        ST_DONE
    } mm_state_e;
endpackage

// File: rtl/mm_ctrl.sv
module mm_ctrl
    import mm_pkg::*;
#(
    parameter int N       = 8,
    parameter int ACC_LAT = 4,
    localparam int IDX_W  = (N > 1) ? $clog2(N) : 1,
    localparam int DR_W   = (ACC_LAT > 2) ? $clog2(ACC_LAT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic [IDX_W-1:0] row,
    output logic [IDX_W-1:0] kix,
    output logic [IDX_W-1:0] col,
    output logic             zero_en,
    output logic             clr_en,
    output logic             issue,
    output logic             wb_en,
    output logic             busy,
    output logic             done
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);
    localparam logic [DR_W-1:0]  DR_LAST = DR_W'(ACC_LAT - 2);

    mm_state_e state_q, state_d;
    logic [DR_W-1:0] dr_q;
    logic col_last;

    assign col_last = (col == LAST);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_ZERO;
            ST_ZERO:  if (col_last && row == LAST) state_d = ST_CLEAR;
            ST_CLEAR: if (col_last) state_d = ST_ACCUM;
            ST_ACCUM: if (col_last && kix == LAST) state_d = ST_DRAIN;
            ST_DRAIN: if (dr_q == DR_LAST) state_d = ST_WBACK;
            ST_WBACK: if (col_last) state_d = (row == LAST) ? ST_DONE : ST_CLEAR;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row  <= '0;
            kix  <= '0;
            col  <= '0;
            dr_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    row <= '0;
                    kix <= '0;
                    col <= '0;
                end
                ST_ZERO: begin
                    col <= col_last ? '0 : col + 1'b1;
                    if (col_last) row <= (row == LAST) ? '0 : row + 1'b1;
                end
                ST_CLEAR: begin
                    col <= col_last ? '0 : col + 1'b1;
                    kix <= '0;
                end
                ST_ACCUM: begin
                    col  <= col_last ? '0 : col + 1'b1;
                    if (col_last) kix <= kix + 1'b1;
                    dr_q <= '0;
                end
                ST_DRAIN: begin
                    dr_q <= dr_q + 1'b1;
                    col  <= '0;
                end
                ST_WBACK: begin
                    col <= col_last ? '0 : col + 1'b1;
                    if (col_last && row != LAST) row <= row + 1'b1;
                end
                ST_DONE: row <= '0;
                default: ;
            endcase
        end
    end

    always_comb begin
        zero_en = 1'b0;
        clr_en  = 1'b0;
        issue   = 1'b0;
        wb_en   = 1'b0;
        busy    = 1'b1;
        done    = 1'b0;
        unique case (state_q)
            ST_IDLE:  busy    = 1'b0;
            ST_ZERO:  zero_en = 1'b1;
            ST_CLEAR: clr_en  = 1'b1;
            ST_ACCUM: issue   = 1'b1;
            ST_DRAIN: ;
            ST_WBACK: wb_en   = 1'b1;
            ST_DONE:  done    = 1'b1;
            default:  busy    = 1'b0;
        endcase
    end

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
endmodule

// File: rtl/mm_rowbuf.sv
module mm_rowbuf #(
    parameter int N      = 8,
    parameter int ACC_W  = 40,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr_en,
    input  logic [IDX_W-1:0]        clr_idx,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic signed [ACC_W-1:0] wr_data,
    input  logic [IDX_W-1:0]        rd_idx,
    output logic signed [ACC_W-1:0] rd_data
);
    logic signed [ACC_W-1:0] ent_q [N];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < N; e++) ent_q[e] <= '0;
        end else if (clr_en) begin
            ent_q[clr_idx] <= '0;
        end else if (wr_en) begin
            ent_q[wr_idx] <= wr_data;
        end
    end

    assign rd_data = ent_q[rd_idx];

    // R9
    clr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |-> !wr_en);
endmodule

// File: rtl/mm_macpipe.sv
module mm_macpipe #(
    parameter int N       = 8,
    parameter int DW      = 16,
    parameter int ACC_W   = 40,
    parameter int ACC_LAT = 4,
    localparam int IDX_W  = (N > 1) ? $clog2(N) : 1,
    localparam int ST     = ACC_LAT - 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    issue,
    input  logic signed [DW-1:0]    a_in,
    input  logic signed [DW-1:0]    b_in,
    input  logic [IDX_W-1:0]        idx_in,
    input  logic signed [ACC_W-1:0] acc_in,
    output logic                    wr_en,
    output logic [IDX_W-1:0]        wr_idx,
    output logic signed [ACC_W-1:0] wr_data,
    output logic                    hit
);
    logic signed [2*DW-1:0]  prod;
    logic signed [ACC_W-1:0] sum;
    logic                    v_q  [ST];
    logic [IDX_W-1:0]        ix_q [ST];
    logic signed [ACC_W-1:0] s_q  [ST];
    logic [ST-1:0]           hit_v;

    assign prod = a_in * b_in;
    assign sum  = acc_in + {{(ACC_W-2*DW){prod[2*DW-1]}}, prod};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_q[0]  <= 1'b0;
            ix_q[0] <= '0;
            s_q[0]  <= '0;
        end else begin
            v_q[0]  <= issue;
            ix_q[0] <= idx_in;
            s_q[0]  <= sum;
        end
    end

    for (genvar s = 1; s < ST; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                v_q[s]  <= 1'b0;
                ix_q[s] <= '0;
                s_q[s]  <= '0;
            end else begin
                v_q[s]  <= v_q[s-1];
                ix_q[s] <= ix_q[s-1];
                s_q[s]  <= s_q[s-1];
            end
        end
    end

    for (genvar s = 0; s < ST; s++) begin : g_hit
        assign hit_v[s] = v_q[s] && (ix_q[s] == idx_in);
    end

    assign hit     = |hit_v;
    assign wr_en   = v_q[ST-1];
    assign wr_idx  = ix_q[ST-1];
    assign wr_data = s_q[ST-1];

    // R5
    raw_hazard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> !hit);
endmodule

// File: rtl/rowbuf_mm.sv
module rowbuf_mm #(
    parameter int N       = 8,
    parameter int DW      = 16,
    parameter int ACC_W   = 40,
    parameter int ACC_LAT = 4,
    localparam int IDX_W  = (N > 1) ? $clog2(N) : 1,
    localparam int ADDR_W = (N > 1) ? $clog2(N*N) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    output logic                    busy,
    output logic                    done,
    output logic [ADDR_W-1:0]       a_addr,
    input  logic signed [DW-1:0]    a_data,
    output logic [ADDR_W-1:0]       b_addr,
    input  logic signed [DW-1:0]    b_data,
    output logic                    c_we,
    output logic [ADDR_W-1:0]       c_addr,
    output logic signed [ACC_W-1:0] c_data
);
    logic [IDX_W-1:0] row, kix, col;
    logic zero_en, clr_en, issue, wb_en, pend_hit;
    logic p_wr_en;
    logic [IDX_W-1:0] p_wr_idx;
    logic signed [ACC_W-1:0] p_wr_data, buf_rd;

    mm_ctrl #(.N(N), .ACC_LAT(ACC_LAT)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start),
        .row(row), .kix(kix), .col(col),
        .zero_en(zero_en), .clr_en(clr_en), .issue(issue), .wb_en(wb_en),
        .busy(busy), .done(done)
    );

    mm_rowbuf #(.N(N), .ACC_W(ACC_W)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .clr_en(clr_en), .clr_idx(col),
        .wr_en(p_wr_en), .wr_idx(p_wr_idx), .wr_data(p_wr_data),
        .rd_idx(col), .rd_data(buf_rd)
    );

    mm_macpipe #(.N(N), .DW(DW), .ACC_W(ACC_W), .ACC_LAT(ACC_LAT)) u_mac (
        .clk(clk), .rst_n(rst_n), .issue(issue),
        .a_in(a_data), .b_in(b_data), .idx_in(col), .acc_in(buf_rd),
        .wr_en(p_wr_en), .wr_idx(p_wr_idx), .wr_data(p_wr_data), .hit(pend_hit)
    );

    assign a_addr = ADDR_W'(row) * ADDR_W'(N) + ADDR_W'(kix);
    assign b_addr = ADDR_W'(kix) * ADDR_W'(N) + ADDR_W'(col);
    assign c_addr = ADDR_W'(row) * ADDR_W'(N) + ADDR_W'(col);
    assign c_we   = zero_en | wb_en;
    assign c_data = wb_en ? buf_rd : '0;

    initial begin
        if (N < ACC_LAT || ACC_LAT < 2)
            $error("rowbuf_mm: parameters need N >= ACC_LAT >= 2");
    end

    // R7
    done_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !c_we);

    // R4
    a_row_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && $past(issue) && b_addr != 0 && ADDR_W'(b_addr % ADDR_W'(N)) != 0)
            |-> $stable(a_addr));

    // R8
    we_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_we |-> busy);
endmodule

// File: tb/rowbuf_mm_bench.sv
module rowbuf_mm_bench;
    localparam int N = 8, DW = 16, ACC_W = 40, LAT = 4;
    localparam int NN = N * N;
    localparam int AW = $clog2(NN);
    localparam int EXP_CYC = NN + N * (2 * N + NN + LAT - 1) + 1;
    // mode: 0 random, 1 identity A, 2 all most-negative, 3 alternating extremes;
    // second field: 1 means a start pulse is poked mid-run
    localparam int VEC [5][2] = '{'{0, 0}, '{1, 0}, '{2, 0}, '{3, 1}, '{0, 1}};

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic busy, done, c_we;
    logic [AW-1:0] a_addr, b_addr, c_addr;
    logic signed [DW-1:0] a_data, b_data;
    logic signed [ACC_W-1:0] c_data;
    logic signed [DW-1:0] ma [NN];
    logic signed [DW-1:0] mb [NN];
    logic signed [ACC_W-1:0] mc [NN];
    int tests = 0, fails = 0;
    int cyc, dn, wr_n, zbad;
    bit mon = 1'b0;

    always #10 clk = ~clk;

    assign a_data = ma[a_addr];
    assign b_data = mb[b_addr];

    rowbuf_mm #(.N(N), .DW(DW), .ACC_W(ACC_W), .ACC_LAT(LAT)) u_rowbuf_mm (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .a_addr(a_addr), .a_data(a_data), .b_addr(b_addr), .b_data(b_data),
        .c_we(c_we), .c_addr(c_addr), .c_data(c_data)
    );

    always @(posedge clk) begin
        if (mon) begin
            if (busy) cyc++;
            if (done) dn++;
            if (c_we) begin
                if (wr_n < NN && (c_data != 0 || int'(c_addr) != wr_n)) zbad++;
                mc[c_addr] <= c_data;
                wr_n++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic fill(input int mode);
        for (int e = 0; e < NN; e++) begin
            unique case (mode)
                1: begin
                    ma[e] = (e / N == e % N) ? 16'sd1 : 16'sd0;
                    mb[e] = DW'($urandom);
                end
                2: begin
                    ma[e] = -16'sd32768;
                    mb[e] = -16'sd32768;
                end
                3: begin
                    ma[e] = (e % 2 == 0) ? 16'sd32767 : -16'sd32768;
                    mb[e] = (e % 3 == 0) ? -16'sd32768 : 16'sd32767;
                end
                default: begin
                    ma[e] = DW'($urandom);
                    mb[e] = DW'($urandom);
                end
            endcase
            mc[e] = 40'sd12345;
        end
    endtask

    task automatic run(input bit poke);
        bit fin = 1'b0;
        cyc = 0; dn = 0; wr_n = 0; zbad = 0; mon = 1'b1;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        for (int t = 0; t < 4000; t++) begin
            @(negedge clk);
            start = (poke && (t == 100 || t == 500));
            if (dn != 0) begin
                fin = 1'b1;
                break;
            end
        end
        start = 1'b0;
        chk(fin, "R7 run finished (watchdog)", fin, 1);
        @(negedge clk);
        mon = 1'b0;
        chk(done == 1'b0, "R7 done one cycle", done, 0);
    endtask

    task automatic check_results(input int mode, input bit poke);
        int bad = 0;
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++) begin
                longint s = 0;
                for (int k = 0; k < N; k++)
                    s += longint'(ma[r*N+k]) * longint'(mb[k*N+c]);
                if (mc[r*N+c] != ACC_W'(s)) begin
                    bad++;
                    if (bad < 4)
                        $display("FAIL R3/R9 mode %0d C[%0d][%0d] actual=%0d expected=%0d",
                                 mode, r, c, mc[r*N+c], ACC_W'(s));
                end
            end
        tests++;
        if (bad != 0) fails++;
        chk(zbad == 0, "R2 zero sweep", zbad, 0);
        chk(cyc == EXP_CYC, poke ? "R8 busy length with stray start" : "R6 busy length",
            cyc, EXP_CYC);
        chk(dn == 1, poke ? "R8 done count with stray start" : "R7 done count", dn, 1);
    endtask

    initial begin
        #4000000;
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!busy && !done && !c_we, "R1 in reset", {busy, done, c_we}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !c_we, "R1 after reset", {busy, done, c_we}, 0);
        for (int v = 0; v < 5; v++) begin
            fill(VEC[v][0]);
            run(VEC[v][1] != 0);
            check_results(VEC[v][0], VEC[v][1] != 0);
        end
        // back-to-back runs: R9 row buffer cleared between runs and rows
        fill(0);
        run(1'b0);
        fill(3);
        run(1'b0);
        check_results(3, 1'b0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule